// File: doc/BRIEF.md
# Fractional Accumulator Baud Rate Generator

This block derives two single-cycle clock-enable pulses from the system clock for a serial port. The fast enable runs at sixteen times the baud rate and paces a receiver that oversamples each bit. The slow enable runs at the baud rate and paces a transmitter. The clock frequency and the baud rate are elaboration parameters. Their defaults are a 50 MHz clock and 38400 baud.

The rate comes from a phase accumulator, not from an integer divider. In every cycle the accumulator is either below the limit or at or above it. Below the limit it gains an increment equal to the oversampling factor times the baud rate. At or above the limit it loses the limit, which equals the clock frequency. The remainder is kept, so the timing error stays bounded and never builds up from one character to the next. The increment is a single derived constant, so it could later be driven from a register without changing the structure.

The accumulator is described as a two-phase machine decoded from its register. In phase PH_ACCUMULATE (value below the limit) the transition adds the increment. In phase PH_WRAP (value at or above the limit) the transition subtracts the limit, and the fast enable is high. A divider counts fast enables. It is in phase DV_COUNT until it reaches the last slot (count equal to the ratio minus one), and then it is in phase DV_LAST. A fast enable in DV_COUNT advances the count. A fast enable in DV_LAST returns the count to zero and raises the slow enable. A synchronous clear returns both machines to zero.

Top module: `frac_baud_gen`

## Requirements
- R1: While `clr` is sampled high at a clock edge, both enables are low in the following cycle. The accumulator and the divider count both restart from zero.
- R2: The first `tick16_o` after `clr` is released comes exactly ceil(CLK_HZ / (16·BAUD)) cycles after the first cycle with clear low. That cycle is cycle 0, and the pulse is high in cycle 82 for the defaults.
- R3: `tick16_o` is high for one cycle at a time and is never high in two consecutive cycles.
- R4: The distance between two successive `tick16_o` pulses is either floor(L/I)+1 or ceil(L/I)+1 cycles, where L = CLK_HZ and I = 16·BAUD. For the defaults this is 82 or 83.
- R5: Over the first N cycles after clear, the number of `tick16_o` pulses is exactly floor(N·I / (L+I)). The remainder is never discarded, so the count never drifts.
- R6: `tick1_o` is high only in a cycle where `tick16_o` is high. It is high on the 16th, 32nd, 48th, … fast pulse counted from clear.
- R7: Over any window that starts at clear, the number of `tick1_o` pulses is floor(P/16), where P is the number of `tick16_o` pulses in that window.
- R8: A clear in the middle of a run discards both the accumulator remainder and the partial divider count. The following pulse train is identical to the train after a fresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous clear, active high |
| tick16_o | output | 1 | One-cycle enable at 16× the baud rate |
| tick1_o | output | 1 | One-cycle enable at the baud rate |

## Verification
The bench looks for the cases where a generator loses or gains time.

- **Long-window counts:** these reveal a design that resets the accumulator to zero instead of subtracting. Such a design drifts low in pulse count as the window grows.
- **Spacing between pulses:** this catches an off-by-one in the compare. Such an error moves the gap set away from the two allowed values.
- **First-pulse latency after clear:** this catches the same compare error from a known starting point.
- **Slow-enable alignment:** this catches a wrong terminal count in the divider.
- **Clear in mid-run:** this catches a divider that keeps its partial count through a clear. Such a divider would raise the slow enable before the 16th fast pulse.

A second instance with a tiny clock-to-baud ratio makes the remainder pattern cycle quickly, so that both allowed gaps occur within a short run.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

    // Phase of the accumulator, decoded from its register value.
    typedef enum logic {
        PH_ACCUMULATE = 1'b0,
        PH_WRAP       = 1'b1
    } acc_phase_t;

    // Phase of the oversample divider.
    typedef enum logic {
        DV_COUNT = 1'b0,
        DV_LAST  = 1'b1
    } div_phase_t;

endpackage

// File: rtl/bgen_accum.sv
module bgen_accum
    import bgen_pkg::*;
#(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned LIMIT = 50_000_000,
    parameter int unsigned INC   = 614_400
) (
    input  logic clk,
    input  logic clr,
    output logic tick_o
);

    localparam logic [ACC_W-1:0] LIM_V   = ACC_W'(LIMIT);
    localparam logic [ACC_W-1:0] INC_V   = ACC_W'(INC);
    localparam logic [ACC_W:0]   BOUND_V = {1'b0, LIM_V} + {1'b0, INC_V};

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    acc_phase_t       phase;

    // Phase decode from the state register.
    always_comb begin
        phase = (acc_q >= LIM_V) ? PH_WRAP : PH_ACCUMULATE;
    end

    // Next-state transition.
    always_comb begin
        unique case (phase)
            PH_ACCUMULATE: acc_d = acc_q + INC_V;
            PH_WRAP:       acc_d = acc_q - LIM_V;
            default:       acc_d = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (clr) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // Output process.
    always_comb begin
        tick_o = (phase == PH_WRAP);
    end

    // The kept remainder never leaves [0, LIMIT+INC).
    assert_acc_bounded_R5: assert property (@(posedge clk) disable iff (clr)
        ({1'b0, acc_q} < BOUND_V));

    // A wrap is always followed by an accumulate cycle.
    assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (clr)
        tick_o |=> !tick_o);

    // A clear leaves the accumulator at zero.
    assert_clear_zero_R1: assert property (@(posedge clk)
        clr |=> (acc_q == '0));

endmodule

// File: rtl/bgen_div.sv
module bgen_div
    import bgen_pkg::*;
#(
    parameter int unsigned RATIO = 16,
    parameter int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic clk,
    input  logic clr,
    input  logic step_i,
    output logic tick_o
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(RATIO - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    div_phase_t       phase;

    always_comb begin
        phase = (cnt_q == LAST_V) ? DV_LAST : DV_COUNT;
    end

    // Next-state transition: only a step moves the count.
    always_comb begin
        cnt_d = cnt_q;
        unique case (phase)
            DV_COUNT: if (step_i) cnt_d = cnt_q + CNT_W'(1);
            DV_LAST:  if (step_i) cnt_d = '0;
            default:  cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Output process.
    always_comb begin
        tick_o = step_i && (phase == DV_LAST);
    end

    assert_hold_without_step_R6: assert property (@(posedge clk) disable iff (clr)
        !step_i |=> $stable(cnt_q));

    assert_restart_after_tick_R6: assert property (@(posedge clk) disable iff (clr)
        tick_o |=> (cnt_q == '0));

    assert_count_in_range_R7: assert property (@(posedge clk) disable iff (clr)
        (cnt_q <= LAST_V));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned BAUD       = 38_400,
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned ACC_W      = 32
) (
    input  logic clk,
    input  logic clr,
    output logic tick16_o,
    output logic tick1_o
);

    localparam int unsigned INC   = OVERSAMPLE * BAUD;
    localparam int unsigned LIMIT = CLK_HZ;

    logic fast_tick;
    logic slow_tick;

    bgen_accum #(
        .ACC_W (ACC_W),
        .LIMIT (LIMIT),
        .INC   (INC)
    ) u_accum (
        .clk    (clk),
        .clr    (clr),
        .tick_o (fast_tick)
    );

    bgen_div #(
        .RATIO (OVERSAMPLE)
    ) u_div (
        .clk    (clk),
        .clr    (clr),
        .step_i (fast_tick),
        .tick_o (slow_tick)
    );

    assign tick16_o = fast_tick;
    assign tick1_o  = slow_tick;

    assert_slow_inside_fast_R6: assert property (@(posedge clk) disable iff (clr)
        tick1_o |-> tick16_o);

    assert_clear_quiet_R1: assert property (@(posedge clk)
        clr |=> (!tick16_o && !tick1_o));

endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;

    localparam longint CLK_A = 50_000_000;
    localparam longint BAUD_A = 38_400;
    localparam longint I_A = 16 * BAUD_A;
    localparam longint CLK_B = 100;
    localparam longint BAUD_B = 3;
    localparam longint I_B = 16 * BAUD_B;

    localparam int NW = 8;
    localparam bit WIN_SEL [NW] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam int WIN_N   [NW] = '{83, 1000, 8000, 30000, 10, 37, 500, 3000};

    logic clk = 1'b0;
    logic clr = 1'b1;
    logic t16_a, t1_a, t16_b, t1_b;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;

    frac_baud_gen dut (
        .clk(clk), .clr(clr), .tick16_o(t16_a), .tick1_o(t1_a)
    );

    frac_baud_gen #(.CLK_HZ(100), .BAUD(3)) dut_small (
        .clk(clk), .clr(clr), .tick16_o(t16_b), .tick1_o(t1_b)
    );

    // Gap / pulse-shape monitors (results reported by the main process).
    int cyc_a = 0, last_a = -1, gap_seen_a = 0, gap_bad_a = 0, b2b_a = 0, orph_a = 0;
    int cyc_b = 0, last_b = -1, gap_seen_b = 0, gap_bad_b = 0, b2b_b = 0, orph_b = 0;
    bit prev_a = 0, prev_b = 0;

    always @(negedge clk) begin
        if (clr) begin
            cyc_a = 0; last_a = -1; prev_a = 0;
        end else begin
            cyc_a++;
            if (t16_a && prev_a) b2b_a++;
            if (t1_a && !t16_a) orph_a++;
            if (t16_a) begin
                if (last_a >= 0) begin
                    gap_seen_a++;
                    if (!((cyc_a - last_a) == int'(CLK_A / I_A) + 1 ||
                          (cyc_a - last_a) == int'((CLK_A + I_A - 1) / I_A) + 1))
                        gap_bad_a++;
                end
                last_a = cyc_a;
            end
            prev_a = t16_a;
        end
    end

    always @(negedge clk) begin
        if (clr) begin
            cyc_b = 0; last_b = -1; prev_b = 0;
        end else begin
            cyc_b++;
            if (t16_b && prev_b) b2b_b++;
            if (t1_b && !t16_b) orph_b++;
            if (t16_b) begin
                if (last_b >= 0) begin
                    gap_seen_b++;
                    if (!((cyc_b - last_b) == int'(CLK_B / I_B) + 1 ||
                          (cyc_b - last_b) == int'((CLK_B + I_B - 1) / I_B) + 1))
                        gap_bad_b++;
                end
                last_b = cyc_b;
            end
            prev_b = t16_b;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Clear for two edges; leaves the bench in cycle 0 at a negedge.
    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 tick16 low after clear", longint'(t16_a), 0);
        check("R1 tick1 low after clear", longint'(t1_a), 0);
        clr = 1'b0;
    endtask

    task automatic count_window(input bit sel, input int n, output longint p16, output longint p1);
        p16 = 0;
        p1 = 0;
        for (int k = 0; k < n; k++) begin
            if (sel ? t16_b : t16_a) p16++;
            if (sel ? t1_b : t1_a) p1++;
            @(negedge clk);
        end
    endtask

    task automatic first_tick(input bit sel, output longint at);
        at = -1;
        for (int k = 0; k < 2000; k++) begin
            if (sel ? t16_b : t16_a) begin
                at = k;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        longint p16, p1, at, expd, n16;

        // R5 / R7: walk the window table from a fresh clear each time.
        for (int w = 0; w < NW; w++) begin
            do_clear();
            count_window(WIN_SEL[w], WIN_N[w], p16, p1);
            if (WIN_SEL[w])
                expd = (longint'(WIN_N[w]) * I_B) / (CLK_B + I_B);
            else
                expd = (longint'(WIN_N[w]) * I_A) / (CLK_A + I_A);
            check("R5 tick16 count in window", p16, expd);
            check("R7 tick1 count in window", p1, p16 / 16);
        end

        // R2: first fast pulse latency, both instances.
        do_clear();
        first_tick(1'b0, at);
        check("R2 first tick16 cycle (default)", at, (CLK_A + I_A - 1) / I_A);
        do_clear();
        first_tick(1'b1, at);
        check("R2 first tick16 cycle (small)", at, (CLK_B + I_B - 1) / I_B);

        // R6: the slow pulse lands on the 16th fast pulse after clear.
        do_clear();
        n16 = 0;
        for (int k = 0; k < 3000; k++) begin
            if (t16_a) n16++;
            if (t1_a) break;
            @(negedge clk);
        end
        check("R6 fast pulses up to first tick1", n16, 16);

        // R8: clear in mid-run, then the train must restart from scratch.
        @(negedge clk);
        count_window(1'b0, 500, p16, p1);
        do_clear();
        first_tick(1'b0, at);
        check("R8 first tick16 after mid-run clear", at, (CLK_A + I_A - 1) / I_A);
        n16 = 0;
        for (int k = 0; k < 3000; k++) begin
            if (t16_a) n16++;
            if (t1_a) break;
            @(negedge clk);
        end
        check("R8 fast pulses to first tick1 after mid-run clear", n16, 16);

        // R3 / R4 / R6 monitor results.
        check("R3 back-to-back tick16 (default)", b2b_a, 0);
        check("R3 back-to-back tick16 (small)", b2b_b, 0);
        check("R4 bad gaps (default)", gap_bad_a, 0);
        check("R4 bad gaps (small)", gap_bad_b, 0);
        check("R4 gaps observed (default)", longint'(gap_seen_a > 10), 1);
        check("R4 gaps observed (small)", longint'(gap_seen_b > 10), 1);
        check("R6 tick1 without tick16 (default)", orph_a, 0);
        check("R6 tick1 without tick16 (small)", orph_b, 0);

        summary();
        $finish;
    end

endmodule